// File: doc/BRIEF.md
# Linked-Descriptor DMA Sequencer

This block moves a run of 32-bit words between a host address space and a local memory. Software sets up a small register bank over a 32-bit register bus. It writes the local start address, the 64-bit host start address, the byte count, the direction and the chaining flag, and then writes the start bit. The sequencer splits the run into host requests of bounded size. It moves the data one word at a time through a pipelined local memory port, which may stall or delay its acknowledge. An optional byte-lane permutation is applied to every data word as it passes through.

When chaining is enabled, the sequencer fetches a seven-word descriptor from host memory at the end of each run. It reloads its working registers from that descriptor and carries on. This repeats until a descriptor arrives with its chain flag clear. Completion sets a sticky done flag, which drives the interrupt output; software clears it by writing one to it. An abort request stops the engine at the next request boundary and leaves a distinct status code behind.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and no host request or local cycle is active.
- R2: While idle, the registers at byte offsets 0x08 (local address), 0x0C/0x10 (host address low/high), 0x14 (byte count), 0x18/0x1C (next pointer low/high) and 0x20 (attributes) read back what was written. Bits [1:0] of the byte count always read 0. Register reads have one cycle of latency.
- R3: A write to 0x00 with bit 0 set starts the engine when status bits [1:0] are 0. With attribute bit 0 = 1, host words read from ascending host addresses are written to ascending local addresses, one word per 4 bytes of count.
- R4: With attribute bit 0 = 0, local words read from ascending local addresses are written to ascending host addresses. Host write requests carry the write flag.
- R5: Host requests carry a byte length of min(128, remaining count). Each request starts 128 bytes after the previous one, and a request's address and length stay stable until it is accepted.
- R6: Control bits [3:2], latched at start, choose the data permutation. With data = {b3,b2,b1,b0}: 0 leaves it unchanged, 1 gives {b0,b1,b2,b3}, 2 gives {b1,b0,b3,b2}, and 3 gives {b2,b3,b0,b1}.
- R7: When the count is used up and attribute bit 1 is set, a 28-byte host read at the next pointer {0x1C,0x18} fetches seven words. In order, they load the local address, host address low, host address high, count, next low, next high and attributes. The engine then continues, and it stops when the loaded attribute bit 1 is clear.
- R8: The interrupt rises only after the last data word has been acknowledged at its destination. Status then reads 0x04. Writing 1 to status bit 2 clears the flag and `irq`, and status then reads 0.
- R9: Writing control bit 1 while busy stops the engine at the next request boundary (a multiple of 128 bytes). Status reads 0x03, `irq` stays low and no more traffic is issued. Writing 0 to control then returns status to 0.
- R10: Writes to offsets 0x08 to 0x20 made while status bits [1:0] read 1 (busy) are ignored, and they do not change the transfer.
- R11: A local request held with stall keeps its address and data stable. Stall and delayed acknowledge cause neither data loss nor reordering.
- R12: A start with count 0 and chaining off issues no traffic and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| irq | output | 1 | Done interrupt (level) |
| hreq_valid | output | 1 | Host request valid |
| hreq_ready | input | 1 | Host request accepted |
| hreq_write | output | 1 | Host request is a write |
| hreq_addr | output | 64 | Host byte address |
| hreq_bytes | output | 8 | Request length in bytes |
| hrsp_valid | input | 1 | Host read data valid |
| hrsp_ready | output | 1 | Host read data taken |
| hrsp_data | input | 32 | Host read data |
| hwd_valid | output | 1 | Host write data valid |
| hwd_ready | input | 1 | Host write data taken |
| hwd_data | output | 32 | Host write data |
| loc_cyc | output | 1 | Local cycle active |
| loc_stb | output | 1 | Local request strobe |
| loc_we | output | 1 | Local write |
| loc_adr | output | 32 | Local byte address |
| loc_dat_w | output | 32 | Local write data |
| loc_stall | input | 1 | Local port stall |
| loc_ack | input | 1 | Local acknowledge |
| loc_dat_r | input | 32 | Local read data |

## Verification
The main transfer is swept over both directions, all four permutation modes, and lengths of one word, exactly one request, one request plus a word, and several requests with a tail. This separates off-by-one errors in chunk splitting from errors in address stepping and lane ordering. Half of the sweep runs with pseudo-random stalls, acknowledge gaps and host flow gaps, which exposes lost or duplicated words that a clean handshake would hide. Separate runs cover a two-link chain with a different address and length per link, an abort in the middle of a transfer, register writes while busy, and a zero-length start.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_DREQ, S_DWORD, S_CREQ, S_HRD,
    S_LWR, S_LACK, S_LRD, S_LRACK, S_HWR, S_FIN
  } seq_state_e;

  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_LAD  = 6'h08;
  localparam logic [5:0] OFS_HLO  = 6'h0C;
  localparam logic [5:0] OFS_HHI  = 6'h10;
  localparam logic [5:0] OFS_CNT  = 6'h14;
  localparam logic [5:0] OFS_NLO  = 6'h18;
  localparam logic [5:0] OFS_NHI  = 6'h1C;
  localparam logic [5:0] OFS_ATTR = 6'h20;

  localparam logic [1:0] CODE_IDLE  = 2'd0;
  localparam logic [1:0] CODE_BUSY  = 2'd1;
  localparam logic [1:0] CODE_ABORT = 2'd3;

  localparam int DESC_WORDS = 7;
endpackage

// File: rtl/dma_lane_swap.sv
module dma_lane_swap (
  input  logic [1:0]  mode,
  input  logic [31:0] din,
  output logic [31:0] dout
);
  always_comb begin
    case (mode)
      2'd1:    dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
      2'd2:    dout = {din[15:0], din[31:16]};
      2'd3:    dout = {din[23:16], din[31:24], din[7:0], din[15:8]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/dma_chunk_sizer.sv
module dma_chunk_sizer #(
  parameter int MAX_CHUNK = 128,
  parameter int LEN_W     = $clog2(MAX_CHUNK) + 1
) (
  input  logic [31:0]      remaining,
  output logic [LEN_W-1:0] chunk
);
  always_comb begin
    if (remaining >= 32'(MAX_CHUNK)) chunk = LEN_W'(MAX_CHUNK);
    else                             chunk = remaining[LEN_W-1:0];
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int MAX_CHUNK = 128,
  parameter int LOC_AW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              hreq_valid,
  input  logic              hreq_ready,
  output logic              hreq_write,
  output logic [63:0]       hreq_addr,
  output logic [$clog2(MAX_CHUNK):0] hreq_bytes,
  input  logic              hrsp_valid,
  output logic              hrsp_ready,
  input  logic [31:0]       hrsp_data,
  output logic              hwd_valid,
  input  logic              hwd_ready,
  output logic [31:0]       hwd_data,
  output logic              loc_cyc,
  output logic              loc_stb,
  output logic              loc_we,
  output logic [LOC_AW-1:0] loc_adr,
  output logic [31:0]       loc_dat_w,
  input  logic              loc_stall,
  input  logic              loc_ack,
  input  logic [31:0]       loc_dat_r
);
  localparam int LEN_W  = $clog2(MAX_CHUNK) + 1;
  localparam int WCNT_W = $clog2(MAX_CHUNK / 4) + 1;
  localparam logic [LEN_W-1:0] DESC_BYTES = LEN_W'(DESC_WORDS * 4);

  seq_state_e        st;
  logic [3:0]        ctrl_q;
  logic [1:0]        code_q, mode_q;
  logic              done_q, abort_pend;
  logic [31:0]       lad_q, hlo_q, hhi_q, cnt_q, nlo_q, nhi_q, attr_q;
  logic [2:0]        dix;
  logic [WCNT_W-1:0] wleft;
  logic [31:0]       wbuf, swap_in, swap_out;
  logic [LEN_W-1:0]  chunk_b;
  logic              busy;

  assign busy    = (code_q == CODE_BUSY);
  assign swap_in = attr_q[0] ? hrsp_data : loc_dat_r;

  dma_lane_swap u_swap (.mode(mode_q), .din(swap_in), .dout(swap_out));
  dma_chunk_sizer #(.MAX_CHUNK(MAX_CHUNK), .LEN_W(LEN_W)) u_size (
    .remaining(cnt_q), .chunk(chunk_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ctrl_q <= '0; code_q <= CODE_IDLE; mode_q <= '0;
      done_q <= 1'b0; abort_pend <= 1'b0;
      lad_q <= '0; hlo_q <= '0; hhi_q <= '0; cnt_q <= '0;
      nlo_q <= '0; nhi_q <= '0; attr_q <= '0;
      dix <= '0; wleft <= '0; wbuf <= '0; reg_rdata <= '0;
    end else begin
      // register bus side
      if (reg_we) begin
        case (reg_addr)
          OFS_CTRL: begin
            ctrl_q <= reg_wdata[3:0];
            if (code_q == CODE_IDLE && reg_wdata[0]) begin
              code_q <= CODE_BUSY; mode_q <= reg_wdata[3:2];
              abort_pend <= 1'b0; st <= S_CHECK;
            end else if (busy && reg_wdata[1]) begin
              abort_pend <= 1'b1;
            end else if (code_q == CODE_ABORT && reg_wdata[1:0] == 2'b00) begin
              code_q <= CODE_IDLE;
            end
          end
          OFS_STAT: if (reg_wdata[2]) done_q <= 1'b0;
          OFS_LAD:  if (!busy) lad_q  <= reg_wdata;
          OFS_HLO:  if (!busy) hlo_q  <= reg_wdata;
          OFS_HHI:  if (!busy) hhi_q  <= reg_wdata;
          OFS_CNT:  if (!busy) cnt_q  <= {reg_wdata[31:2], 2'b00};
          OFS_NLO:  if (!busy) nlo_q  <= reg_wdata;
          OFS_NHI:  if (!busy) nhi_q  <= reg_wdata;
          OFS_ATTR: if (!busy) attr_q <= reg_wdata;
          default: ;
        endcase
      end
      // sequencer
      case (st)
        S_CHECK: begin
          if (abort_pend) begin
            code_q <= CODE_ABORT; abort_pend <= 1'b0; st <= S_IDLE;
          end else if (cnt_q != 0) st <= S_CREQ;
          else if (attr_q[1])      st <= S_DREQ;
          else                     st <= S_FIN;
        end
        S_DREQ: if (hreq_ready) begin dix <= '0; st <= S_DWORD; end
        S_DWORD: if (hrsp_valid) begin
          case (dix)
            3'd0: lad_q  <= hrsp_data;
            3'd1: hlo_q  <= hrsp_data;
            3'd2: hhi_q  <= hrsp_data;
            3'd3: cnt_q  <= {hrsp_data[31:2], 2'b00};
            3'd4: nlo_q  <= hrsp_data;
            3'd5: nhi_q  <= hrsp_data;
            default: attr_q <= hrsp_data;
          endcase
          dix <= dix + 3'd1;
          if (dix == 3'(DESC_WORDS - 1)) st <= S_CHECK;
        end
        S_CREQ: if (hreq_ready) begin
          wleft <= WCNT_W'(chunk_b >> 2);
          st    <= attr_q[0] ? S_HRD : S_LRD;
        end
        S_HRD:   if (hrsp_valid) begin wbuf <= swap_out; st <= S_LWR; end
        S_LWR:   if (!loc_stall) st <= S_LACK;
        S_LRD:   if (!loc_stall) st <= S_LRACK;
        S_LRACK: if (loc_ack) begin wbuf <= swap_out; st <= S_HWR; end
        S_LACK, S_HWR: if ((st == S_LACK && loc_ack) || (st == S_HWR && hwd_ready)) begin
          lad_q <= lad_q + 32'd4;
          {hhi_q, hlo_q} <= {hhi_q, hlo_q} + 64'd4;
          cnt_q <= cnt_q - 32'd4;
          wleft <= wleft - 1'b1;
          if (wleft == 1) st <= S_CHECK;
          else            st <= (st == S_LACK) ? S_HRD : S_LRD;
        end
        S_FIN: begin done_q <= 1'b1; code_q <= CODE_IDLE; st <= S_IDLE; end
        default: ;
      endcase
      // registered read-back
      case (reg_addr)
        OFS_CTRL: reg_rdata <= {28'd0, ctrl_q};
        OFS_STAT: reg_rdata <= {29'd0, done_q, code_q};
        OFS_LAD:  reg_rdata <= lad_q;
        OFS_HLO:  reg_rdata <= hlo_q;
        OFS_HHI:  reg_rdata <= hhi_q;
        OFS_CNT:  reg_rdata <= cnt_q;
        OFS_NLO:  reg_rdata <= nlo_q;
        OFS_NHI:  reg_rdata <= nhi_q;
        OFS_ATTR: reg_rdata <= attr_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign irq        = done_q;
  assign hreq_valid = (st == S_DREQ) || (st == S_CREQ);
  assign hreq_write = (st == S_CREQ) && !attr_q[0];
  assign hreq_addr  = (st == S_DREQ) ? {nhi_q, nlo_q} : {hhi_q, hlo_q};
  assign hreq_bytes = (st == S_DREQ) ? DESC_BYTES : chunk_b;
  assign hrsp_ready = (st == S_DWORD) || (st == S_HRD);
  assign hwd_valid  = (st == S_HWR);
  assign hwd_data   = wbuf;
  assign loc_cyc    = (st == S_LWR) || (st == S_LACK) || (st == S_LRD) || (st == S_LRACK);
  assign loc_stb    = (st == S_LWR) || (st == S_LRD);
  assign loc_we     = (st == S_LWR) || (st == S_LACK);
  assign loc_adr    = lad_q[LOC_AW-1:0];
  assign loc_dat_w  = wbuf;

  AST_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    loc_stb && loc_stall |=> loc_stb && $stable(loc_adr) && $stable(loc_dat_w)); // R11
  AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (rst)
    hreq_valid |-> (hreq_bytes != 0) && (hreq_bytes <= LEN_W'(MAX_CHUNK))); // R5
  AST_HREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    hreq_valid && !hreq_ready |=> hreq_valid && $stable(hreq_addr) && $stable(hreq_bytes)); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (code_q == CODE_ABORT) |-> !loc_cyc && !hreq_valid && !hwd_valid); // R9
  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !loc_cyc && !hwd_valid && !hreq_valid); // R8
  AST_SIDE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(loc_cyc && (hwd_valid || hrsp_ready))); // R4
endmodule

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_we = 1'b0, irq;
  logic        hreq_valid, hreq_ready = 1'b0, hreq_write;
  logic [63:0] hreq_addr;
  logic [7:0]  hreq_bytes;
  logic        hrsp_valid = 1'b0, hrsp_ready;
  logic [31:0] hrsp_data = '0;
  logic        hwd_valid, hwd_ready = 1'b0;
  logic [31:0] hwd_data;
  logic        loc_cyc, loc_stb, loc_we, loc_stall = 1'b0, loc_ack = 1'b0;
  logic [31:0] loc_adr, loc_dat_w, loc_dat_r = '0;

  dma_chain_seq uut (.*);

  logic [31:0] hm [0:1023];
  logic [31:0] lm [0:1023];
  int rd_ptr, rd_left, wr_ptr, pend_adr, lwr_cnt, hwr_cnt, hdr_n;
  bit pend, stress;
  logic [15:0] lf = 16'hACE1;
  logic [63:0] hdr_addr [0:63];
  int hdr_bytes [0:63];
  bit hdr_wr [0:63];
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // host and local memory models: decide drives at negedge, record handshakes that fire next edge
  always @(negedge clk) begin
    cyc++;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (rst) begin
      rd_left = 0; pend = 0; hrsp_valid = 0; hreq_ready = 0; hwd_ready = 0;
      loc_ack = 0; loc_stall = 0;
    end else begin
      hrsp_valid = (rd_left > 0) && !(stress && lf[0]);
      hrsp_data  = hm[rd_ptr % 1024];
      if (hrsp_valid && hrsp_ready) begin rd_ptr++; rd_left--; end
      hreq_ready = (rd_left == 0) && !(stress && lf[1]);
      if (hreq_valid && hreq_ready) begin
        if (hdr_n < 64) begin
          hdr_addr[hdr_n] = hreq_addr; hdr_bytes[hdr_n] = int'(hreq_bytes);
          hdr_wr[hdr_n] = hreq_write;
        end
        hdr_n++;
        if (hreq_write) wr_ptr = int'(hreq_addr[11:2]);
        else begin rd_ptr = int'(hreq_addr[11:2]); rd_left = int'(hreq_bytes) / 4; end
      end
      hwd_ready = !(stress && lf[2]);
      if (hwd_valid && hwd_ready) begin hm[wr_ptr % 1024] = hwd_data; wr_ptr++; hwr_cnt++; end
      loc_ack = 0;
      if (pend && !(stress && lf[3])) begin loc_ack = 1; loc_dat_r = lm[pend_adr]; pend = 0; end
      loc_stall = stress && lf[4];
      if (loc_stb && !loc_stall) begin
        pend = 1; pend_adr = int'(loc_adr[11:2]);
        if (loc_we) begin lm[pend_adr] = loc_dat_w; lwr_cnt++; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b0;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1; break; end
    end
  endtask

  function automatic logic [31:0] swp(input logic [31:0] d, input int m);
    case (m)
      1: return {d[7:0], d[15:8], d[23:16], d[31:24]};
      2: return {d[15:0], d[31:16]};
      3: return {d[23:16], d[31:24], d[7:0], d[15:8]};
      default: return d;
    endcase
  endfunction

  task automatic clear_mems(input int seed);
    for (int i = 0; i < 1024; i++) begin
      hm[i] = 32'(i) * 32'h9E3779B1 + 32'(seed);
      lm[i] = 32'(i) * 32'h7F4A7C15 ^ 32'(seed);
    end
  endtask

  task automatic finish_and_clear(input string tag);
    logic [31:0] r;
    reg_rd(6'h04, r); chk(r == 32'h4, {tag, " R8 status done"}, r, 32'h4);
    reg_wr(6'h04, 32'h4);
    reg_rd(6'h04, r); chk(r == 32'h0 && !irq, {tag, " R8 w1c"}, {r[30:0], irq}, 32'h0);
  endtask

  task automatic run_xfer(input int dir, input int mode, input int n, input bit str);
    bit seen; int bad; int nw; logic [31:0] e, a;
    nw = n / 4; bad = 0;
    clear_mems(n * 7 + mode * 3 + dir);
    if (dir == 1) lm[256 + nw] = 32'hDEADBEEF; else hm[128 + nw] = 32'hDEADBEEF;
    hdr_n = 0; stress = str; lwr_cnt = 0; hwr_cnt = 0;
    reg_wr(6'h08, 32'h400); reg_wr(6'h0C, 32'h200); reg_wr(6'h10, 0);
    reg_wr(6'h14, 32'(n));  reg_wr(6'h20, 32'(dir));
    reg_wr(6'h00, 32'((mode << 2) | 1));
    wait_irq(seen);
    chk(seen, "R8 irq raised", 32'(seen), 1);
    for (int i = 0; i < nw; i++) begin
      if (dir == 1) begin e = swp(hm[128 + i], mode); a = lm[256 + i]; end
      else          begin e = swp(lm[256 + i], mode); a = hm[128 + i]; end
      if (a !== e && bad == 0) begin
        chk(0, $sformatf("R3 R4 R6 R11 dir%0d mode%0d n%0d word%0d", dir, mode, n, i), a, e);
      end
      if (a !== e) bad++;
    end
    if (bad == 0) chk(1, "R3 R4 R6", 0, 0);
    a = (dir == 1) ? lm[256 + nw] : hm[128 + nw];
    chk(a == 32'hDEADBEEF, "R3 R4 word past end untouched", a, 32'hDEADBEEF);
    bad = 0;
    if (hdr_n != (n + 127) / 128) bad = 1;
    for (int k = 0; k < hdr_n && k < 64; k++) begin
      if (hdr_bytes[k] != ((n - k * 128) > 128 ? 128 : n - k * 128)) bad = 1;
      if (hdr_addr[k] != 64'(32'h200 + k * 128)) bad = 1;
      if (hdr_wr[k] != (dir == 0)) bad = 1;
    end
    chk(bad == 0, $sformatf("R5 request list n%0d", n), 32'(hdr_n), 32'((n + 127) / 128));
    finish_and_clear("sweep");
    stress = 0;
  endtask

  initial begin
    for (int i = 0; i < 160000; i++) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r; bit seen;
    int lens [4] = '{4, 128, 132, 260};
    clear_mems(1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a <= 32; a += 4) begin
      reg_rd(6'(a), r); chk(r == 0, $sformatf("R1 reset reg 0x%02h", a), r, 0);
    end
    chk(!irq && !hreq_valid && !loc_cyc, "R1 outputs idle", {29'd0, irq, hreq_valid, loc_cyc}, 0);

    // R2 read-back
    reg_wr(6'h08, 32'h1111_2220); reg_rd(6'h08, r); chk(r == 32'h1111_2220, "R2 local addr", r, 32'h1111_2220);
    reg_wr(6'h0C, 32'hFFAC_CE55); reg_rd(6'h0C, r); chk(r == 32'hFFAC_CE55, "R2 host lo", r, 32'hFFAC_CE55);
    reg_wr(6'h10, 32'h1BAD_CAFE); reg_rd(6'h10, r); chk(r == 32'h1BAD_CAFE, "R2 host hi", r, 32'h1BAD_CAFE);
    reg_wr(6'h14, 32'h0000_1237); reg_rd(6'h14, r); chk(r == 32'h0000_1234, "R2 count low bits", r, 32'h1234);
    reg_wr(6'h18, 32'h0000_0A5C); reg_rd(6'h18, r); chk(r == 32'h0000_0A5C, "R2 next lo", r, 32'hA5C);
    reg_wr(6'h1C, 32'h0000_0007); reg_rd(6'h1C, r); chk(r == 32'h7, "R2 next hi", r, 32'h7);
    reg_wr(6'h20, 32'h0000_0002); reg_rd(6'h20, r); chk(r == 32'h2, "R2 attr", r, 32'h2);
    reg_wr(6'h18, 0); reg_wr(6'h1C, 0);

    // R3 R4 R5 R6 R11 sweep
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 4; l++)
          run_xfer(d, m, lens[l], (l % 2) == 1);

    // R7 chained descriptors
    clear_mems(77);
    hm[512] = 32'h600; hm[513] = 32'h300; hm[514] = 0; hm[515] = 40;
    hm[516] = 0; hm[517] = 0; hm[518] = 1;
    hdr_n = 0; stress = 1;
    reg_wr(6'h08, 32'h400); reg_wr(6'h0C, 32'h200); reg_wr(6'h10, 0);
    reg_wr(6'h14, 64); reg_wr(6'h18, 32'h800); reg_wr(6'h1C, 0);
    reg_wr(6'h20, 3); reg_wr(6'h00, 1);
    wait_irq(seen);
    chk(seen, "R7 chain irq", 32'(seen), 1);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) if (lm[256 + i] !== hm[128 + i]) bad++;
      for (int i = 0; i < 10; i++) if (lm[384 + i] !== hm[192 + i]) bad++;
      chk(bad == 0, "R7 both links copied", 32'(bad), 0);
    end
    chk(hdr_n == 3 && hdr_addr[1] == 64'h800 && hdr_bytes[1] == 28 && !hdr_wr[1],
        "R7 descriptor fetch request", 32'(hdr_n), 3);
    reg_rd(6'h08, r); chk(r == 32'h628, "R7 local addr after chain", r, 32'h628);
    reg_rd(6'h20, r); chk(r == 32'h1, "R7 attr loaded", r, 32'h1);
    stress = 0;
    finish_and_clear("chain");

    // R10 writes while busy ignored
    clear_mems(91);
    hm[128 + 64] = 32'hDEADBEEF;
    hwr_cnt = 0; stress = 1;
    reg_wr(6'h08, 32'h400); reg_wr(6'h0C, 32'h200); reg_wr(6'h10, 0);
    reg_wr(6'h14, 256); reg_wr(6'h18, 0); reg_wr(6'h20, 0); reg_wr(6'h00, 1);
    while (hwr_cnt < 2) @(negedge clk);
    reg_wr(6'h14, 32'h1000); reg_wr(6'h0C, 32'h0); reg_wr(6'h08, 0); reg_wr(6'h20, 32'h3);
    wait_irq(seen);
    chk(hwr_cnt == 64, "R10 word count unchanged", 32'(hwr_cnt), 64);
    chk(hm[128 + 64] == 32'hDEADBEEF && hm[128] == lm[256] && hm[191] == lm[319],
        "R10 destination unchanged", hm[128 + 64], 32'hDEADBEEF);
    reg_rd(6'h20, r); chk(r == 0, "R10 attr kept", r, 0);
    stress = 0;
    finish_and_clear("busy");

    // R9 abort
    clear_mems(5);
    lwr_cnt = 0; stress = 1;
    reg_wr(6'h08, 32'h400); reg_wr(6'h0C, 32'h200); reg_wr(6'h14, 512);
    reg_wr(6'h20, 1); reg_wr(6'h00, 1);
    while (lwr_cnt < 1) @(negedge clk);
    reg_wr(6'h00, 2);
    r = 1;
    for (int i = 0; i < 3000 && r[1:0] == 2'd1; i++) reg_rd(6'h04, r);
    chk(r == 32'h3, "R9 abort status", r, 3);
    repeat (50) @(negedge clk);
    chk(!irq, "R9 no irq on abort", 32'(irq), 0);
    chk(lwr_cnt > 0 && lwr_cnt < 128 && (lwr_cnt % 32) == 0, "R9 stopped at boundary", 32'(lwr_cnt), 32);
    chk(!loc_cyc && !hreq_valid, "R9 quiet", {30'd0, loc_cyc, hreq_valid}, 0);
    reg_wr(6'h00, 0);
    reg_rd(6'h04, r); chk(r == 0, "R9 cleared by control write", r, 0);
    stress = 0;

    // R12 zero count
    hdr_n = 0; lwr_cnt = 0;
    reg_wr(6'h14, 0); reg_wr(6'h20, 0); reg_wr(6'h00, 1);
    wait_irq(seen);
    chk(seen && hdr_n == 0 && lwr_cnt == 0, "R12 empty transfer", 32'(hdr_n), 0);
    finish_and_clear("R12");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule